// File: doc/BRIEF.md
# Burst Bus Access Sequencer

This block is the master-side sequencer for an external bus on which address and data share one set of lines. A request arrives from an internal queue through a valid/ready handshake. It carries a start address, a direction and a transfer count of one to four words. For writes it also carries every write word. The sequencer then walks the bus through its phases. One address cycle comes first, with the strobe high and the address on the shared lines. Data cycles follow, one transfer per cycle in which the target raises ready. A recovery phase comes last and holds until the target drops ready again.

The same ready input ends each data transfer and also keeps recovery open. As a result, a target can stretch any transfer and the turnaround after it without a second signal. A new access can start straight out of the last recovery cycle. The controller does not have to pass through idle first. A simple hold request parks the bus with its drivers released. It is taken only at the boundary between accesses.

Top module: `burst_bus_seq`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, bus_state is 0 (idle), bus_strobe, bus_last, ad_oe, hold_ack and rd_valid are low, and req_ready is high when hold_req is low.
- R2: A request accepted in a cycle (req_valid and req_ready high) gives, in the next cycle, exactly one address cycle: bus_state 1, bus_strobe high, ad_out equal to the captured req_addr, ad_oe high and bus_wr equal to req_write.
- R3: The address cycle is always followed by the data state (bus_state 2). A transfer completes only in a data cycle where bus_rdy is high. With bus_rdy low the controller stays on the same transfer for any number of cycles.
- R4: req_beats holds the transfer count minus one (0 gives 1 word, 3 gives 4 words). The access performs exactly that many transfers back to back in the data state, with no further strobe.
- R5: bus_last is high in every data cycle of the final transfer of an access, and low in all other cycles.
- R6: For a read, the cycle after a data cycle with bus_rdy high shows rd_valid high, rd_data equal to ad_in as sampled, and rd_idx equal to the transfer number (0 to 3). Otherwise rd_valid is low.
- R7: For a write, during the data cycles of transfer k, ad_oe is high and ad_out carries bits [k*32 +: 32] of req_wdata as captured at acceptance. For a read, ad_oe is low in the data state.
- R8: After the last transfer the controller is in recovery (bus_state 3) for as long as bus_rdy stays high. In the recovery cycle with bus_rdy low, req_ready is high unless hold_req is high. The next state is the address state if a request is accepted in that cycle, and idle otherwise.
- R9: During the data cycles of transfer k, beat_addr equals the start address plus 4*k, modulo 2^32.
- R10: With hold_req high in idle, or in the final recovery cycle, the next state is hold (bus_state 4). In hold, hold_ack is high, req_ready is low, and ad_oe and bus_strobe are low. The controller returns to idle in the cycle after hold_req is seen low.
- R11: hold_req raised during the address or data state has no effect on the access: hold_ack stays low until recovery ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 32 | Start address of the access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_beats | input | 2 | Transfer count minus one |
| req_wdata | input | 128 | Write words, word k in bits [k*32 +: 32] |
| rd_valid | output | 1 | Read word delivered |
| rd_idx | output | 2 | Transfer number of the delivered word |
| rd_data | output | 32 | Delivered read word |
| bus_strobe | output | 1 | Address strobe, high in the address cycle |
| bus_last | output | 1 | Final transfer of the access in progress |
| bus_wr | output | 1 | Direction qualifier during address and data |
| bus_rdy | input | 1 | Target ready: ends a transfer, holds recovery |
| ad_in | input | 32 | Shared lines as sampled |
| ad_out | output | 32 | Value driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| hold_req | input | 1 | Request to park the bus |
| hold_ack | output | 1 | Bus parked and released |
| bus_state | output | 3 | 0 idle, 1 address, 2 data, 3 recovery, 4 hold |
| beat_addr | output | 32 | Address of the current transfer |

## Verification
The strobe, the address on the lines and the direction are due one cycle after the accepting edge. bus_last, beat_addr and the write word follow in the same cycle as the data state they describe. A read word shows up one edge after the ready-qualified cycle. The bench drives all inputs at the falling edge. It checks the combinational outputs a moment later in that same cycle, and checks registered read results at the falling edge after the capturing rising edge. Each access task walks cycle by cycle, with a random count of waits per transfer and of recovery cycles. Expected values are derived from the task's own arguments, so every check samples the cycle in which the value is due.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_DATA = 3'd2,
        ST_REC  = 3'd3,
        ST_HOLD = 3'd4
    } bbs_state_e;
endpackage

// File: rtl/bbs_ctrl.sv
module bbs_ctrl
    import bbs_pkg::*;
#(
    parameter int MAX_BEATS = 4,
    localparam int CW = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [CW-1:0] req_beats,
    input  logic          hold_req,
    input  logic          bus_rdy,
    output logic          req_ready,
    output logic          accept,
    output bbs_state_e    state,
    output logic [CW-1:0] beat,
    output logic          bus_strobe,
    output logic          bus_last,
    output logic          hold_ack
);
    typedef struct packed {
        bbs_state_e    st;
        logic [CW-1:0] beat;
        logic [CW-1:0] last;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        req_ready = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (hold_req) begin
                    ctl_d.st = ST_HOLD;
                end else begin
                    req_ready = 1'b1;
                    if (req_valid) begin
                        ctl_d.st   = ST_ADDR;
                        ctl_d.beat = '0;
                        ctl_d.last = req_beats;
                    end
                end
            end
            ST_ADDR: ctl_d.st = ST_DATA;
            ST_DATA: begin
                if (bus_rdy) begin
                    if (ctl_q.beat == ctl_q.last) ctl_d.st = ST_REC;
                    else ctl_d.beat = ctl_q.beat + 1'b1;
                end
            end
            ST_REC: begin
                if (!bus_rdy) begin
                    if (hold_req) begin
                        ctl_d.st = ST_HOLD;
                    end else begin
                        req_ready = 1'b1;
                        if (req_valid) begin
                            ctl_d.st   = ST_ADDR;
                            ctl_d.beat = '0;
                            ctl_d.last = req_beats;
                        end else begin
                            ctl_d.st = ST_IDLE;
                        end
                    end
                end
            end
            ST_HOLD: if (!hold_req) ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.beat <= '0;
            ctl_q.last <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign accept     = req_ready && req_valid;
    assign state      = ctl_q.st;
    assign beat       = ctl_q.beat;
    assign bus_strobe = (ctl_q.st == ST_ADDR);
    assign bus_last   = (ctl_q.st == ST_DATA) && (ctl_q.beat == ctl_q.last);
    assign hold_ack   = (ctl_q.st == ST_HOLD);
endmodule

// File: rtl/bbs_dpath.sv
module bbs_dpath
    import bbs_pkg::*;
#(
    parameter int DW        = 32,
    parameter int MAX_BEATS = 4,
    localparam int CW  = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1,
    localparam int BSH = $clog2(DW / 8)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept,
    input  logic [DW-1:0]           req_addr,
    input  logic                    req_write,
    input  logic [MAX_BEATS*DW-1:0] req_wdata,
    input  bbs_state_e              state,
    input  logic [CW-1:0]           beat,
    input  logic                    bus_rdy,
    input  logic [DW-1:0]           ad_in,
    output logic [DW-1:0]           ad_out,
    output logic                    ad_oe,
    output logic                    bus_wr,
    output logic [DW-1:0]           beat_addr,
    output logic                    rd_valid,
    output logic [CW-1:0]           rd_idx,
    output logic [DW-1:0]           rd_data
);
    typedef struct packed {
        logic [DW-1:0]                 addr;
        logic                          wr;
        logic [MAX_BEATS-1:0][DW-1:0]  words;
        logic                          rd_v;
        logic [CW-1:0]                 rd_i;
        logic [DW-1:0]                 rd_d;
    } dp_t;

    dp_t dp_d, dp_q;
    logic [MAX_BEATS-1:0][DW-1:0] wd_split;
    logic in_access;
    logic take;

    for (genvar g = 0; g < MAX_BEATS; g++) begin : g_split
        assign wd_split[g] = req_wdata[g*DW +: DW];
    end

    assign in_access = (state == ST_ADDR) || (state == ST_DATA);
    assign take      = (state == ST_DATA) && bus_rdy;

    always_comb begin
        dp_d      = dp_q;
        dp_d.rd_v = 1'b0;
        if (accept) begin
            dp_d.addr  = req_addr;
            dp_d.wr    = req_write;
            dp_d.words = wd_split;
        end
        if (take && !dp_q.wr) begin
            dp_d.rd_v = 1'b1;
            dp_d.rd_i = beat;
            dp_d.rd_d = ad_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        if (state == ST_ADDR) begin
            ad_out = dp_q.addr;
            ad_oe  = 1'b1;
        end else if (state == ST_DATA && dp_q.wr) begin
            ad_out = dp_q.words[beat];
            ad_oe  = 1'b1;
        end
    end

    assign bus_wr    = in_access && dp_q.wr;
    assign beat_addr = dp_q.addr + (DW'(beat) << BSH);
    assign rd_valid  = dp_q.rd_v;
    assign rd_idx    = dp_q.rd_i;
    assign rd_data   = dp_q.rd_d;
endmodule

// File: rtl/burst_bus_seq.sv
module burst_bus_seq
    import bbs_pkg::*;
#(
    parameter int DW        = 32,
    parameter int MAX_BEATS = 4,
    localparam int CW = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [DW-1:0]           req_addr,
    input  logic                    req_write,
    input  logic [CW-1:0]           req_beats,
    input  logic [MAX_BEATS*DW-1:0] req_wdata,
    output logic                    rd_valid,
    output logic [CW-1:0]           rd_idx,
    output logic [DW-1:0]           rd_data,
    output logic                    bus_strobe,
    output logic                    bus_last,
    output logic                    bus_wr,
    input  logic                    bus_rdy,
    input  logic [DW-1:0]           ad_in,
    output logic [DW-1:0]           ad_out,
    output logic                    ad_oe,
    input  logic                    hold_req,
    output logic                    hold_ack,
    output logic [2:0]              bus_state,
    output logic [DW-1:0]           beat_addr
);
    bbs_state_e    st;
    logic [CW-1:0] beat;
    logic          accept;

    bbs_ctrl #(.MAX_BEATS(MAX_BEATS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_beats (req_beats),
        .hold_req  (hold_req),
        .bus_rdy   (bus_rdy),
        .req_ready (req_ready),
        .accept    (accept),
        .state     (st),
        .beat      (beat),
        .bus_strobe(bus_strobe),
        .bus_last  (bus_last),
        .hold_ack  (hold_ack)
    );

    bbs_dpath #(.DW(DW), .MAX_BEATS(MAX_BEATS)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .state     (st),
        .beat      (beat),
        .bus_rdy   (bus_rdy),
        .ad_in     (ad_in),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .bus_wr    (bus_wr),
        .beat_addr (beat_addr),
        .rd_valid  (rd_valid),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data)
    );

    assign bus_state = st;
endmodule

// File: rtl/bbs_checker.sv
module bbs_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    bus_state,
    input logic          bus_strobe,
    input logic          bus_last,
    input logic          bus_wr,
    input logic          bus_rdy,
    input logic          req_ready,
    input logic          hold_req,
    input logic          hold_ack,
    input logic          ad_oe,
    input logic          rd_valid,
    input logic [DW-1:0] beat_addr
);
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> !bus_strobe);

    p_addr_to_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> (bus_state == 3'd2));

    p_wait_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == 3'd2 && !bus_rdy) |=> (bus_state == 3'd2 && $stable(beat_addr)));

    p_last_in_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_last |-> (bus_state == 3'd2));

    p_read_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_state == 3'd2 && bus_rdy && !bus_wr));

    p_rec_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == 3'd3 && bus_rdy) |=> (bus_state == 3'd3));

    p_ready_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!hold_req && (bus_state == 3'd0 || (bus_state == 3'd3 && !bus_rdy))));

    p_hold_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!ad_oe && !bus_strobe && !req_ready));

    p_no_hold_mid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == 3'd1 || bus_state == 3'd2) |=> !hold_ack);
endmodule

bind burst_bus_seq bbs_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_state (bus_state),
    .bus_strobe(bus_strobe),
    .bus_last  (bus_last),
    .bus_wr    (bus_wr),
    .bus_rdy   (bus_rdy),
    .req_ready (req_ready),
    .hold_req  (hold_req),
    .hold_ack  (hold_ack),
    .ad_oe     (ad_oe),
    .rd_valid  (rd_valid),
    .beat_addr (beat_addr)
);

// File: tb/test_burst_bus_seq.sv
module test_burst_bus_seq;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_write, bus_rdy, hold_req;
    logic [31:0]  req_addr, ad_in;
    logic [1:0]   req_beats;
    logic [127:0] req_wdata;
    logic         req_ready, rd_valid, bus_strobe, bus_last, bus_wr, ad_oe, hold_ack;
    logic [1:0]   rd_idx;
    logic [31:0]  rd_data, ad_out, beat_addr;
    logic [2:0]   bus_state;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;

    always #(CLK_P / 2) clk = ~clk;

    burst_bus_seq i_burst_bus_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_beats(req_beats), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data),
        .bus_strobe(bus_strobe), .bus_last(bus_last), .bus_wr(bus_wr),
        .bus_rdy(bus_rdy), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .hold_req(hold_req), .hold_ack(hold_ack),
        .bus_state(bus_state), .beat_addr(beat_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [127:0] wd, input int k);
        return wd[k*32 +: 32];
    endfunction

    function automatic logic [31:0] addr_of(input logic [31:0] base, input int k);
        return base + 32'(4 * k);
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Starts in a cycle where a request may be taken; ends in the final recovery cycle.
    task automatic access(input logic [31:0] a, input bit wr, input int n,
                          input logic [127:0] wd, input int maxw, input bit hold_mid);
        logic [31:0] d;
        req_valid = 1'b1; req_addr = a; req_write = wr;
        req_beats = 2'(n - 1); req_wdata = wd; bus_rdy = 1'b0;
        #1 chk(req_ready == 1'b1, "R8 accept window", 64'(req_ready), 64'd1);
        step();
        req_valid = 1'b0; req_addr = $urandom; req_wdata = {4{$urandom}};
        if (hold_mid) hold_req = 1'b1;
        #1;
        chk(bus_state == 3'd1, "R2 address state", 64'(bus_state), 64'd1);
        chk(bus_strobe == 1'b1, "R2 strobe", 64'(bus_strobe), 64'd1);
        chk(ad_out == a && ad_oe, "R2 address on lines", 64'(ad_out), 64'(a));
        chk(bus_wr == wr, "R2 direction", 64'(bus_wr), 64'(wr));
        chk(rd_valid == 1'b0, "R6 no read in address", 64'(rd_valid), 64'd0);
        step();
        for (int k = 0; k < n; k++) begin
            int w;
            w = $urandom_range(0, maxw);
            if (maxw > 3) w = maxw;
            for (int j = 0; j <= w; j++) begin
                bus_rdy = (j == w);
                d = $urandom;
                ad_in = d;
                #1;
                chk(bus_state == 3'd2, "R3 data state", 64'(bus_state), 64'd2);
                chk(bus_strobe == 1'b0, "R4 no strobe in burst", 64'(bus_strobe), 64'd0);
                chk(bus_last == (k == n - 1), "R5 last flag", 64'(bus_last), 64'(k == n - 1));
                chk(beat_addr == addr_of(a, k), "R9 beat address", 64'(beat_addr), 64'(addr_of(a, k)));
                chk(hold_ack == 1'b0, "R11 no hold mid access", 64'(hold_ack), 64'd0);
                if (wr) chk(ad_oe && ad_out == word_of(wd, k), "R7 write word", 64'(ad_out), 64'(word_of(wd, k)));
                else    chk(ad_oe == 1'b0, "R7 read releases lines", 64'(ad_oe), 64'd0);
                step();
                if (!wr && j == w)
                    chk(rd_valid && rd_data == d && rd_idx == 2'(k), "R6 read word",
                        {rd_valid, 29'd0, rd_idx, rd_data}, {1'b1, 29'd0, 2'(k), d});
            end
        end
        for (int j = 0; j < int'($urandom_range(0, 2)); j++) begin
            #1;
            chk(bus_state == 3'd3, "R8 recovery held", 64'(bus_state), 64'd3);
            chk(req_ready == 1'b0, "R8 no accept while ready high", 64'(req_ready), 64'd0);
            chk(bus_last == 1'b0, "R5 last low in recovery", 64'(bus_last), 64'd0);
            step();
        end
        bus_rdy = 1'b0;
        #1;
        chk(bus_state == 3'd3, "R8 final recovery", 64'(bus_state), 64'd3);
        chk(req_ready == !hold_req, "R8 ready in final recovery", 64'(req_ready), 64'(!hold_req));
    endtask

    task automatic expect_idle(input string req);
        step();
        #1;
        chk(bus_state == 3'd0 && req_ready, req, 64'(bus_state), 64'd0);
    endtask

    task automatic expect_hold(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            step();
            #1;
            chk(bus_state == 3'd4 && hold_ack, "R10 hold entered", 64'(bus_state), 64'd4);
            chk(!ad_oe && !bus_strobe && !req_ready, "R10 released in hold",
                {ad_oe, bus_strobe, req_ready}, 64'd0);
        end
        hold_req = 1'b0;
        expect_idle("R10 back to idle");
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; bus_rdy = 1'b0;
        hold_req = 1'b0; req_addr = '0; ad_in = '0; req_beats = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(bus_state == 3'd0, "R1 reset state", 64'(bus_state), 64'd0);
        chk(!bus_strobe && !bus_last && !ad_oe && !hold_ack && !rd_valid, "R1 outputs quiet",
            {bus_strobe, bus_last, ad_oe, hold_ack, rd_valid}, 64'd0);
        rst_n = 1'b1;
        step();
        #1 chk(req_ready == 1'b1 && bus_state == 3'd0, "R1 idle after reset", 64'(req_ready), 64'd1);
        @(negedge clk);

        // R4 R9: four-word read wrapping the address space
        access(32'hFFFF_FFF8, 1'b0, 4, '0, 3, 1'b0);
        expect_idle("R8 idle after access");
        // R7: single write, then back-to-back three-word write
        access(32'h0000_1000, 1'b1, 1, 128'h4444_4444_3333_3333_2222_2222_1111_1111, 2, 1'b0);
        access(32'h0000_2000, 1'b1, 3, 128'hDDDD_DDDD_CCCC_CCCC_BBBB_BBBB_AAAA_AAAA, 2, 1'b0);
        expect_idle("R8 idle after back-to-back");
        // R3: long wait on every transfer
        access(32'h0000_3000, 1'b0, 2, '0, 20, 1'b0);
        expect_idle("R3 idle after long wait");
        // R10: hold from idle
        hold_req = 1'b1;
        #1 chk(req_ready == 1'b0, "R10 no accept with hold", 64'(req_ready), 64'd0);
        expect_hold(3);
        @(negedge clk);
        // R11: hold raised mid access waits for recovery end
        access(32'h0000_4000, 1'b0, 3, '0, 2, 1'b1);
        expect_hold(2);
        @(negedge clk);

        for (int t = 0; t < 60; t++) begin
            access($urandom & 32'hFFFF_FFFC, 1'($urandom), int'($urandom_range(1, 4)),
                   {$urandom, $urandom, $urandom, $urandom}, 3, 1'b0);
            if ($urandom_range(0, 1) == 0) begin
                expect_idle("R8 idle after random access");
                @(negedge clk);
            end
        end
        step();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule